// File: doc/BRIEF.md
# Aligned Conversion Result Register with Byte-Pair Read Lock

This block keeps the most recent 10-bit converter result and shows it to a byte-wide bus as a high byte and a low byte. The result is placed in a 16-bit word. Left alignment puts the result at the top of the word. Right alignment puts it at the bottom. The alignment select is taken together with each new result, so a change to the select acts on the next stored result only.

Software has to read the two bytes in a fixed order that depends on the alignment. In right alignment the low byte comes first. In left alignment the high byte comes first. The byte read first always shows the newest stored word. The other byte comes from a shadow register, which is loaded only when the first byte is read. A new result that arrives between the two reads therefore cannot change the second byte, and a byte pair never combines two conversions.

Top module: `aligned_result_reg`

## Requirements
- R1: After reset, both `hi_byte` and `lo_byte` read 0x00.
- R2: When a result is stored with `align_right`=0, `hi_byte` shows result bits [9:2] from the next cycle on. Once `rd_hi` has been strobed, `lo_byte` shows result bits [1:0] in its bits [7:6].
- R3: When a result is stored with `align_right`=1, `lo_byte` shows result bits [7:0] from the next cycle on. Once `rd_lo` has been strobed, `hi_byte` shows result bits [9:8] in its bits [1:0].
- R4: Bits that carry no result bits read as zero: `lo_byte`[5:0] in left alignment and `hi_byte`[7:2] in right alignment.
- R5: In right alignment, `hi_byte` changes only on a `rd_lo` strobe or a new result. A `rd_hi` strobe has no effect.
- R6: In left alignment, `lo_byte` changes only on a `rd_hi` strobe or a new result. A `rd_lo` strobe has no effect.
- R7: After the first byte has been read, a new result arriving before the next first-byte read leaves the second byte at the value it had when the snapshot was taken.
- R8: `align_right` is sampled only while `res_valid` is high. With no result strobe and no read strobe, both output bytes hold their values even if `align_right` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Strobe: store `res_data` in this cycle |
| res_data | input | 10 | Conversion result |
| align_right | input | 1 | 1 = right-aligned, 0 = left-aligned; sampled together with `res_valid` |
| rd_hi | input | 1 | Strobe: bus read of the high byte |
| rd_lo | input | 1 | Strobe: bus read of the low byte |
| hi_byte | output | 8 | High byte of the 16-bit data word |
| lo_byte | output | 8 | Low byte of the 16-bit data word |

## Verification
The bench builds the block with the default parameters, a 10-bit result and 8-bit bytes. With these values the word has six pad bits, which sit at the bottom of the low byte in left alignment and at the top of the high byte in right alignment. Both zero-fill cases can therefore be observed at the ports. With these parameters the bench can check the exact bit split of a result across the two bytes. It can also place a new result between the two reads of a pair, and it can switch the alignment while a stale shadow byte is still showing.

// File: rtl/aligned_result_reg.sv
module aligned_result_reg #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              align_right,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_byte
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] word_q;
  logic              right_q;
  logic [BYTE_W-1:0] shadow_q;

  wire [WORD_W-1:0] word_d = align_right ? {{PAD_W{1'b0}}, res_data}
                                         : {res_data, {PAD_W{1'b0}}};
  wire [BYTE_W-1:0] word_hi  = word_q[WORD_W-1:BYTE_W];
  wire [BYTE_W-1:0] word_lo  = word_q[BYTE_W-1:0];
  wire              first_rd = right_q ? rd_lo : rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      right_q  <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (res_valid) begin
        word_q  <= word_d;
        right_q <= align_right;
      end
      if (first_rd)
        shadow_q <= right_q ? word_hi : word_lo;
    end
  end

  assign hi_byte = right_q ? shadow_q : word_hi;
  assign lo_byte = right_q ? word_lo  : shadow_q;

  AST_LEFT_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !align_right) |=> hi_byte == $past(res_data[RES_W-1 -: BYTE_W])); // R2
  AST_RIGHT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && align_right) |=> lo_byte == $past(res_data[BYTE_W-1:0])); // R3
  AST_LEFT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!right_q && rd_hi && !res_valid) |=> lo_byte[PAD_W-1:0] == '0); // R4
  AST_RIGHT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (right_q && rd_lo && !res_valid) |=> hi_byte[BYTE_W-1:RES_W-BYTE_W] == '0); // R4
  AST_RIGHT_HIGH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (right_q && !rd_lo && !res_valid) |=> $stable(hi_byte)); // R5
  AST_LEFT_LOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!right_q && !rd_hi && !res_valid) |=> $stable(lo_byte)); // R6
  AST_SNAPSHOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (right_q && !rd_lo && res_valid && align_right) |=> $stable(hi_byte)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !rd_hi && !rd_lo) |=> ($stable(hi_byte) && $stable(lo_byte))); // R8
endmodule

// File: tb/aligned_result_reg_tb_top.sv
module aligned_result_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       align_right = 1'b0;
  logic       rd_hi = 1'b0;
  logic       rd_lo = 1'b0;
  logic [7:0] hi_byte, lo_byte;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  aligned_result_reg dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .align_right(align_right), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .hi_byte(hi_byte), .lo_byte(lo_byte)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic store(input logic [9:0] d, input logic right);
    @(negedge clk);
    res_valid = 1'b1; res_data = d; align_right = right;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic pulse(input logic hi, input logic lo);
    @(negedge clk);
    rd_hi = hi; rd_lo = lo;
    @(negedge clk);
    rd_hi = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 hi after reset", hi_byte, 8'h00);
    chk("R1 lo after reset", lo_byte, 8'h00);
  endtask

  task automatic t_left;
    store(10'h2AD, 1'b0);
    chk("R2 left hi", hi_byte, 8'hAB);
    chk("R6 left lo before first read", lo_byte, 8'h00);
    pulse(1'b0, 1'b1);
    chk("R6 rd_lo ignored in left", lo_byte, 8'h00);
    pulse(1'b1, 1'b0);
    chk("R2 left lo after hi read", lo_byte, 8'h40);
    chk("R4 left pad bits", {2'b00, lo_byte[5:0]}, 8'h00);
  endtask

  task automatic t_right;
    store(10'h3C5, 1'b1);
    chk("R3 right lo", lo_byte, 8'hC5);
    chk("R5 right hi stale before read", hi_byte, 8'h40);
    pulse(1'b1, 1'b0);
    chk("R5 rd_hi ignored in right", hi_byte, 8'h40);
    pulse(1'b0, 1'b1);
    chk("R3 right hi after lo read", hi_byte, 8'h03);
    chk("R4 right pad bits", {hi_byte[7:2], 2'b00}, 8'h00);
  endtask

  task automatic t_mid_read;
    store(10'h155, 1'b1);
    pulse(1'b0, 1'b1);
    chk("R7 pair hi", hi_byte, 8'h01);
    store(10'h2AA, 1'b1);
    chk("R7 snapshot kept after new result", hi_byte, 8'h01);
    chk("R3 new lo shown", lo_byte, 8'hAA);
    pulse(1'b0, 1'b1);
    chk("R7 next pair hi", hi_byte, 8'h02);
  endtask

  task automatic t_align_change;
    @(negedge clk);
    align_right = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 lo held on select change", lo_byte, 8'hAA);
    chk("R8 hi held on select change", hi_byte, 8'h02);
    store(10'h0FF, 1'b0);
    chk("R8 new alignment on next result", hi_byte, 8'h3F);
    pulse(1'b1, 1'b0);
    chk("R2 lo after switch", lo_byte, 8'hC0);
  endtask

  task automatic t_left_mid_read;
    store(10'h3FF, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R2 lo snapshot", lo_byte, 8'hC0);
    store(10'h001, 1'b0);
    chk("R7 left snapshot kept", lo_byte, 8'hC0);
    chk("R2 hi of new result", hi_byte, 8'h00);
    pulse(1'b1, 1'b0);
    chk("R2 lo of new result", lo_byte, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_left;
    t_right;
    t_mid_read;
    t_align_change;
    t_left_mid_read;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule